// File: doc/BRIEF.md
# DMA Lane Transform and Checksum Stage

This block sits in the data path of one DMA channel, between the side that reads memory and the side that writes it. Each accepted beat is a 32-bit word with a size code of one, two or four bytes. The stage can reorder the byte lanes of the word and can mirror the bit order inside every byte. It registers the result toward the write side and, in the same cycle, folds the valid bytes of the transformed word into a checksum accumulator. The accumulator can run one of four algorithms, or it can be left untouched.

A transfer begins with a one-cycle `start` pulse, which captures the 6-bit function code. A separate `restart` pulse reloads the accumulator with the seed value of the selected algorithm. The host can read `csum_out` at any time, usually once a single unchained transfer has drained. Back-pressure from the write side travels back through `in_ready`, so no beat is ever lost.

Top module: `dma_lane_xform`

## Requirements
- R1: After reset, `out_valid` is 0, `in_ready` is 1, the latched function is "no reorder, no mirror, no checksum" and `csum_out` reads 0.
- R2: The lane field is `func_sel[1:0]`. Let output byte j be `out_data[8j+7:8j]` and input byte i be `in_data[8i+7:8i]`. Code 0 passes byte j through from byte j. Code 1 takes byte j from byte 3-j, which reverses the whole word. Code 2 takes byte j from byte j XOR 2, which swaps the two halfwords. Code 3 takes byte j from byte j XOR 1, which swaps the bytes inside each halfword.
- R3: When `func_sel[2]` is 1, the bit order inside each byte is reversed after the lane reordering. It combines with any lane code.
- R4: While `out_valid` is 1 and `out_ready` is 0, `out_data` and `out_size` hold steady and `in_ready` is 0. Every accepted beat appears at the output exactly once, in order, one cycle after acceptance. `out_size` repeats the beat's `in_size`.
- R5: `func_sel` is captured only in a cycle where `start` is 1. A beat accepted in that same cycle already uses the new code. Changes to `func_sel` at any other time have no effect.
- R6: `restart` loads the accumulator with the seed of the active algorithm: 0 for CRC-16, 0xFFFF for CRC-CCITT, 0xFFFFFFFF for CRC-32, 0 for the Internet sum and 0 for no checksum. A beat accepted in the restart cycle is folded in after the seed is loaded.
- R7: Checksum code 1 (`func_sel[5:3]`) is CRC-16 with polynomial 0x8005, processed MSB first, and read unreflected in `csum_out[15:0]`. The bytes "123456789" give 0xFEE8.
- R8: Checksum code 2 is CRC-CCITT with polynomial 0x1021, processed MSB first. The bytes "123456789" give 0x29B1.
- R9: Checksum code 3 is reflected CRC-32 with polynomial 0x04C11DB7. `csum_out` shows the accumulator XORed with 0xFFFFFFFF. The bytes "123456789" give 0xCBF43926.
- R10: Checksum code 4 is a 16-bit ones'-complement sum with end-around carry. A 4-byte beat adds `w[31:16]` and `w[15:0]`. A 2-byte beat adds `w[15:0]`. A 1-byte beat adds `{w[7:0],8'h00}`.
- R11: `in_size` code 0 means 1 byte, code 1 means 2 bytes, and codes 2 and 3 mean 4 bytes. Only the lowest byte lanes of the transformed word are valid, as many as the size gives. The CRCs consume the valid lanes from the highest down to lane 0.
- R12: Checksum codes 0, 5, 6 and 7 leave the accumulator unchanged, and `csum_out` shows it unmodified.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Transfer start, captures `func_sel` |
| func_sel | input | 6 | {checksum[2:0], mirror, lane[1:0]} |
| restart | input | 1 | Reload accumulator with algorithm seed |
| in_valid | input | 1 | Input beat present |
| in_ready | output | 1 | Stage can take a beat |
| in_data | input | 32 | Input word |
| in_size | input | 2 | Beat size code |
| out_valid | output | 1 | Transformed beat present |
| out_ready | input | 1 | Downstream takes the beat |
| out_data | output | 32 | Transformed word |
| out_size | output | 2 | Size code of the output beat |
| csum_out | output | 32 | Running checksum result |

## Verification
Two functions can fall in the same cycle: an accumulator restart and the folding of an accepted beat. A `start` can also coincide with a beat that must already obey the new code. The bench provokes this directly by asserting `restart` together with the first bytes of "123456789" partway through a CRC-32 run. It then checks for the standard 0xCBF43926, which appears only if the seed is loaded before that beat is folded. Random runs also pair `start`/`restart` with beats under random back-pressure. The result is judged against a bench model that applies seed, then fold, in that order.

// File: rtl/dlx_pkg.sv
package dlx_pkg;
  localparam int LANES  = 4;
  localparam int BYTE_W = 8;
  localparam int WORD_W = LANES * BYTE_W;
  localparam int HALF_W = WORD_W / 2;

  typedef enum logic [1:0] {
    LANE_KEEP = 2'd0, LANE_REV4 = 2'd1, LANE_HALFSWAP = 2'd2, LANE_PAIRSWAP = 2'd3
  } lane_mode_e;

  typedef enum logic [2:0] {
    CK_NONE = 3'd0, CK_CRC16 = 3'd1, CK_CCITT = 3'd2, CK_CRC32 = 3'd3,
    CK_INET = 3'd4, CK_RSV5 = 3'd5, CK_RSV6 = 3'd6, CK_RSV7 = 3'd7
  } ck_mode_e;

  typedef struct packed {
    ck_mode_e   ck;
    logic       mirror;
    lane_mode_e lane;
  } func_t;

  function automatic logic [BYTE_W-1:0] flip8(input logic [BYTE_W-1:0] b);
    logic [BYTE_W-1:0] r;
    for (int i = 0; i < BYTE_W; i++) r[i] = b[BYTE_W-1-i];
    return r;
  endfunction

  function automatic logic [WORD_W-1:0] permute(input lane_mode_e m, input logic [WORD_W-1:0] w);
    logic [WORD_W-1:0] r;
    for (int j = 0; j < LANES; j++) begin
      int src;
      case (m)
        LANE_REV4:     src = LANES - 1 - j;
        LANE_HALFSWAP: src = (j + LANES/2) % LANES;
        LANE_PAIRSWAP: src = (j % 2 == 0) ? j + 1 : j - 1;
        default:       src = j;
      endcase
      r[j*BYTE_W +: BYTE_W] = w[src*BYTE_W +: BYTE_W];
    end
    return r;
  endfunction

  function automatic logic [WORD_W-1:0] ck_seed(input ck_mode_e c);
    case (c)
      CK_CCITT: return 32'h0000_FFFF;
      CK_CRC32: return 32'hFFFF_FFFF;
      default:  return '0;
    endcase
  endfunction

  function automatic logic [WORD_W-1:0] crc_byte(input ck_mode_e c, input logic [WORD_W-1:0] acc,
                                                 input logic [BYTE_W-1:0] b);
    logic [HALF_W-1:0] h;
    logic [WORD_W-1:0] x;
    logic fb;
    h = acc[HALF_W-1:0];
    x = acc;
    case (c)
      CK_CRC16, CK_CCITT: begin
        for (int i = BYTE_W-1; i >= 0; i--) begin
          fb = h[HALF_W-1] ^ b[i];
          h  = {h[HALF_W-2:0], 1'b0} ^ (fb ? ((c == CK_CRC16) ? 16'h8005 : 16'h1021) : 16'h0);
        end
        return {{(WORD_W-HALF_W){1'b0}}, h};
      end
      CK_CRC32: begin
        for (int i = 0; i < BYTE_W; i++) begin
          fb = x[0] ^ b[i];
          x  = (x >> 1) ^ (fb ? 32'hEDB8_8320 : 32'h0);
        end
        return x;
      end
      default: return acc;
    endcase
  endfunction

  function automatic logic [HALF_W-1:0] ones_add(input logic [HALF_W-1:0] a, input logic [HALF_W-1:0] v);
    logic [HALF_W:0] s;
    s = {1'b0, a} + {1'b0, v};
    return s[HALF_W-1:0] + {{(HALF_W-1){1'b0}}, s[HALF_W]};
  endfunction

  function automatic int size_bytes(input logic [1:0] sz);
    return (sz == 2'd0) ? 1 : (sz == 2'd1) ? 2 : LANES;
  endfunction

  function automatic logic [WORD_W-1:0] fold(input ck_mode_e c, input logic [WORD_W-1:0] acc,
                                             input logic [WORD_W-1:0] w, input logic [1:0] sz);
    logic [WORD_W-1:0] a;
    logic [HALF_W-1:0] s;
    a = acc;
    if (c == CK_INET) begin
      s = acc[HALF_W-1:0];
      if (sz == 2'd0)      s = ones_add(s, {w[BYTE_W-1:0], {BYTE_W{1'b0}}});
      else if (sz == 2'd1) s = ones_add(s, w[HALF_W-1:0]);
      else                 s = ones_add(ones_add(s, w[WORD_W-1:HALF_W]), w[HALF_W-1:0]);
      a = {{(WORD_W-HALF_W){1'b0}}, s};
    end else begin
      for (int k = LANES-1; k >= 0; k--)
        if (k < size_bytes(sz)) a = crc_byte(c, a, w[k*BYTE_W +: BYTE_W]);
    end
    return a;
  endfunction
endpackage

// File: rtl/dlx_lane_xform.sv
module dlx_lane_xform
  import dlx_pkg::*;
(
  input  func_t              fn,
  input  logic [WORD_W-1:0]  din,
  output logic [WORD_W-1:0]  dout
);
  logic [WORD_W-1:0] perm_w;

  assign perm_w = permute(fn.lane, din);

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign dout[g*BYTE_W +: BYTE_W] = fn.mirror ? flip8(perm_w[g*BYTE_W +: BYTE_W])
                                                : perm_w[g*BYTE_W +: BYTE_W];
  end
endmodule

// File: rtl/dlx_csum_acc.sv
module dlx_csum_acc
  import dlx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  ck_mode_e          ck,
  input  logic              restart,
  input  logic              beat,
  input  logic [WORD_W-1:0] word,
  input  logic [1:0]        size,
  output logic [WORD_W-1:0] acc_q
);
  logic [WORD_W-1:0] seed_w, base_w, next_w;

  assign seed_w = ck_seed(ck);
  assign base_w = restart ? seed_w : acc_q;
  assign next_w = beat ? fold(ck, base_w, word, size) : base_w;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) acc_q <= '0;
    else        acc_q <= next_w;
  end

  // R6: a restart with no beat leaves exactly the seed
  p_seed_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
    restart && !beat |=> acc_q == $past(seed_w));

  // R12: a beat under no checksum leaves the accumulator alone
  p_none_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !restart && beat && (ck == CK_NONE) |=> $stable(acc_q));

  // R7: CRC-16 keeps the upper half clear after a seed load
  p_crc16_width_r7: assert property (@(posedge clk) disable iff (!rst_n)
    restart && (ck == CK_CRC16) |=> acc_q[WORD_W-1:HALF_W] == '0);
endmodule

// File: rtl/dma_lane_xform.sv
module dma_lane_xform
  import dlx_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic [5:0]  func_sel,
  input  logic        restart,
  input  logic        in_valid,
  output logic        in_ready,
  input  logic [31:0] in_data,
  input  logic [1:0]  in_size,
  output logic        out_valid,
  input  logic        out_ready,
  output logic [31:0] out_data,
  output logic [1:0]  out_size,
  output logic [31:0] csum_out
);
  func_t             mode_q, eff_w;
  logic              beat_w, stall_w;
  logic [WORD_W-1:0] xf_w, acc_w;

  assign eff_w    = start ? func_t'(func_sel) : mode_q;
  assign stall_w  = out_valid && !out_ready;
  assign in_ready = !stall_w;
  assign beat_w   = in_valid && in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mode_q <= '0;
    else if (start) mode_q <= func_t'(func_sel);
  end

  dlx_lane_xform u_xf (.fn(eff_w), .din(in_data), .dout(xf_w));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
      out_size  <= '0;
    end else if (beat_w) begin
      out_valid <= 1'b1;
      out_data  <= xf_w;
      out_size  <= in_size;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  dlx_csum_acc u_acc (
    .clk(clk), .rst_n(rst_n), .ck(eff_w.ck), .restart(restart),
    .beat(beat_w), .word(xf_w), .size(in_size), .acc_q(acc_w)
  );

  assign csum_out = (mode_q.ck == CK_CRC32) ? ~acc_w : acc_w;

  // R4: a stalled output beat holds still
  p_hold_out_r4: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_size));

  // R4: nothing is taken while the output is blocked
  p_no_take_r4: assert property (@(posedge clk) disable iff (!rst_n)
    stall_w |-> !beat_w);

  // R5: the latched function moves only on start
  p_mode_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !start |=> $stable(mode_q));
endmodule

// File: tb/dma_lane_xform_bench.sv
module dma_lane_xform_bench;
  localparam int PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 0, restart = 0, in_valid = 0, out_ready = 0;
  logic [5:0] func_sel = '0;
  logic [31:0] in_data = '0;
  logic [1:0] in_size = '0;
  logic in_ready, out_valid;
  logic [31:0] out_data, csum_out;
  logic [1:0] out_size;

  int total = 0, bad = 0;
  logic [33:0] exp_q[$];
  logic [5:0]  m_fn = '0;
  logic [31:0] m_acc = '0;

  always #(PERIOD/2) clk = ~clk;

  dma_lane_xform u_dma_lane_xform (
    .clk(clk), .rst_n(rst_n), .start(start), .func_sel(func_sel), .restart(restart),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data), .in_size(in_size),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .out_size(out_size), .csum_out(csum_out)
  );

  function automatic logic [31:0] b_xform(input logic [5:0] fs, input logic [31:0] d);
    logic [31:0] r;
    int x;
    x = (fs[1:0] == 2'd1) ? 3 : (fs[1:0] == 2'd2) ? 2 : (fs[1:0] == 2'd3) ? 1 : 0;
    for (int j = 0; j < 4; j++) r[j*8 +: 8] = d[(j ^ x)*8 +: 8];
    if (fs[2]) for (int b = 0; b < 32; b++) r[b] = d[((b/8) ^ x)*8 + 7 - (b%8)];
    return r;
  endfunction

  function automatic logic [31:0] b_seed(input logic [2:0] c);
    return (c == 3'd2) ? 32'hFFFF : (c == 3'd3) ? 32'hFFFFFFFF : 32'h0;
  endfunction

  function automatic logic [31:0] b_fold(input logic [2:0] c, input logic [31:0] acc,
                                         input logic [31:0] w, input logic [1:0] sz);
    int n;
    logic [31:0] a;
    logic [7:0] by;
    logic [15:0] poly;
    n = (sz == 0) ? 1 : (sz == 1) ? 2 : 4;
    a = acc;
    if (c == 3'd4) begin
      logic [31:0] s;
      if (n == 1)      s = acc[15:0] + {16'h0, w[7:0], 8'h00};
      else if (n == 2) s = acc[15:0] + {16'h0, w[15:0]};
      else             s = acc[15:0] + {16'h0, w[31:16]} + {16'h0, w[15:0]};
      s = {16'h0, s[15:0]} + {16'h0, s[31:16]};
      s = {16'h0, s[15:0]} + {16'h0, s[31:16]};
      return {16'h0, s[15:0]};
    end
    if (c < 3'd1 || c > 3'd3) return acc;
    poly = (c == 3'd1) ? 16'h8005 : 16'h1021;
    for (int k = n - 1; k >= 0; k--) begin
      by = w[k*8 +: 8];
      for (int i = 0; i < 8; i++) begin
        if (c == 3'd3) a = (a[0] ^ by[i]) ? ((a >> 1) ^ 32'hEDB88320) : (a >> 1);
        else a = {16'h0, (a[15] ^ by[7-i]) ? ({a[14:0], 1'b0} ^ poly) : {a[14:0], 1'b0}};
      end
    end
    return a;
  endfunction

  function automatic logic [31:0] b_read(input logic [2:0] c, input logic [31:0] a);
    return (c == 3'd3) ? (a ^ 32'hFFFFFFFF) : a;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // one clock: drive at negedge, book handshakes, return at next negedge
  task automatic cyc(input bit iv, input logic [31:0] d, input logic [1:0] sz, input bit ordy,
                     input bit st, input logic [5:0] fs, input bit rs, output bit took);
    logic [5:0] eff;
    logic [33:0] e;
    in_valid = iv; in_data = d; in_size = sz; out_ready = ordy;
    start = st; func_sel = fs; restart = rs;
    #1;
    took = iv && in_ready;
    if (out_valid && !ordy) chk("R4 stall in_ready", {31'h0, in_ready}, 32'h0);
    if (out_valid && ordy) begin
      e = exp_q.pop_front();
      chk("R2 R3 R4 data", out_data, e[31:0]);
      chk("R4 size", {30'h0, out_size}, {30'h0, e[33:32]});
    end
    eff = st ? fs : m_fn;
    if (st) m_fn = fs;
    if (rs) m_acc = b_seed(eff[5:3]);
    if (took) begin
      exp_q.push_back({sz, b_xform(eff, d)});
      m_acc = b_fold(eff[5:3], m_acc, b_xform(eff, d), sz);
    end
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic send(input logic [31:0] d, input logic [1:0] sz, input logic [5:0] fs, input int rdy_pct);
    bit took;
    took = 0;
    while (!took) cyc(1, d, sz, ($urandom % 100) < rdy_pct, 0, fs, 0, took);
  endtask

  task automatic begin_xfer(input logic [5:0] fs, input bit rs);
    bit took;
    cyc(0, '0, '0, 1, 1, fs, rs, took);
  endtask

  task automatic drain();
    bit took;
    while (exp_q.size() != 0 || out_valid) cyc(0, '0, '0, 1, 0, m_fn, 0, took);
  endtask

  task automatic send_digits(input logic [5:0] fs);
    send(32'h31323334, 2'd2, fs, 100);
    send(32'h35363738, 2'd3, fs, 100);
    send(32'h00000039, 2'd0, fs, 100);
    drain();
  endtask

  initial begin
    #(PERIOD * 150000);
    bad++;
    total++;
    $display("FAIL watchdog expired act=running exp=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    bit took;
    void'($urandom(32'd2718));
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 out_valid", {31'h0, out_valid}, 32'h0);
    chk("R1 in_ready", {31'h0, in_ready}, 32'h1);
    chk("R1 csum", csum_out, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);

    // R9 R11 CRC-32 check string, lanes consumed high to low
    begin_xfer({3'd3, 1'b0, 2'd0}, 1);
    send_digits({3'd3, 1'b0, 2'd0});
    chk("R9 crc32 check", csum_out, 32'hCBF43926);
    // R8 CRC-CCITT
    begin_xfer({3'd2, 1'b0, 2'd0}, 1);
    send_digits({3'd2, 1'b0, 2'd0});
    chk("R8 ccitt check", csum_out, 32'h000029B1);
    // R12 no checksum: previous value untouched, no restart
    begin_xfer({3'd0, 1'b1, 2'd1}, 0);
    send(32'hDEADBEEF, 2'd2, m_fn, 100);
    send(32'h00000055, 2'd0, m_fn, 100);
    drain();
    chk("R12 none holds", csum_out, 32'h000029B1);
    // R7 CRC-16
    begin_xfer({3'd1, 1'b0, 2'd0}, 1);
    send_digits({3'd1, 1'b0, 2'd0});
    chk("R7 crc16 check", csum_out, 32'h0000FEE8);
    // R10 R11 Internet sum with end-around carry, then 1-byte beat
    begin_xfer({3'd4, 1'b0, 2'd0}, 1);
    send(32'hFFFF0001, 2'd2, m_fn, 100);
    drain();
    chk("R10 inet carry", csum_out, 32'h00000001);
    send(32'hAAAA0012, 2'd0, m_fn, 100);
    drain();
    chk("R10 R11 inet byte", csum_out, 32'h00001201);
    // R2 R3 every lane code with and without mirror
    for (int l = 0; l < 8; l++) begin
      begin_xfer({3'd0, l[2:0]}, 0);
      send(32'h11223344, 2'd2, m_fn, 100);
    end
    drain();
    begin_xfer({3'd0, 1'b0, 2'd1}, 0);
    cyc(1, 32'h11223344, 2'd2, 1, 0, m_fn, 0, took);
    chk("R2 reverse literal", out_data, 32'h44332211);
    cyc(1, 32'h0F0F0101, 2'd2, 1, 1, {3'd0, 1'b1, 2'd3}, 0, took);
    chk("R3 R5 mirror pairswap literal", out_data, 32'hF0F08080);
    drain();
    // R5 func_sel changes without start are ignored
    begin_xfer({3'd3, 1'b0, 2'd0}, 1);
    send(32'h31323334, 2'd2, {3'd2, 1'b1, 2'd1}, 100);
    send(32'h35363738, 2'd2, {3'd1, 1'b0, 2'd2}, 100);
    send(32'h00000039, 2'd0, {3'd4, 1'b1, 2'd3}, 100);
    drain();
    chk("R5 mid-transfer change ignored", csum_out, 32'hCBF43926);
    // R6 restart coincides with an accepted beat
    begin_xfer({3'd3, 1'b0, 2'd0}, 1);
    send(32'h12345678, 2'd2, m_fn, 100);
    took = 0;
    while (!took) cyc(1, 32'h31323334, 2'd2, 1, 0, m_fn, 1, took);
    send(32'h35363738, 2'd2, m_fn, 100);
    send(32'h00000039, 2'd0, m_fn, 100);
    drain();
    chk("R6 restart with beat", csum_out, 32'hCBF43926);
    // R4 sustained back-pressure
    begin_xfer({3'd2, 1'b1, 2'd2}, 1);
    cyc(1, 32'hCAFEF00D, 2'd2, 0, 0, m_fn, 0, took);
    repeat (4) begin
      logic [31:0] held;
      held = out_data;
      cyc(1, 32'h01020304, 2'd1, 0, 0, m_fn, 0, took);
      chk("R4 held data", out_data, held);
    end
    drain();
    chk("R4 R8 csum after stall", csum_out, b_read(m_fn[5:3], m_acc));
    // random transfers
    for (int t = 0; t < 60; t++) begin
      logic [5:0] fs;
      int nb;
      fs = {3'($urandom % 5), 3'($urandom)};
      nb = 1 + $urandom % 16;
      begin_xfer(fs, ($urandom % 4) != 0);
      for (int b = 0; b < nb; b++)
        send($urandom, 2'($urandom), 6'($urandom), 60);
      if (($urandom % 3) == 0) begin
        took = 0;
        while (!took) cyc(1, $urandom, 2'($urandom), 1, 0, m_fn, 1, took);
      end
      drain();
      chk("R6 R7 R8 R9 R10 R11 R12 random csum", csum_out, b_read(m_fn[5:3], m_acc));
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule